// File: doc/BRIEF.md
# SPI Command-Address Transaction Engine

This block is an SPI master that carries out whole transactions of the kind that serial flash and register-mapped peripherals expect. Each transaction is one frame under a single chip-select assertion. The frame holds an 8-bit command and can be followed by a 24-bit address. After the address there can be a data phase of a chosen number of bytes. The user hands over a packed operation word, a 2-bit operation kind and a byte count through a valid/ready handshake. During a write, each data byte is requested through a second valid/ready handshake just before it is shifted out. During a read, every received byte is returned with a strobe one system clock long.

The serial clock runs at half the system clock. Each bit takes two system cycles: one at the idle level set by the `CPOL` parameter, then one at the active level. MOSI is updated when SCLK returns to idle. MISO is captured by the system clock at the edge that ends the active half. The design never uses SCLK as a clock.

The controller is a state machine with these states:

- `ST_IDLE`: ready for an operation.
- `ST_CMD`: command bits.
- `ST_ADDR`: address bits.
- `ST_WWAIT`: waiting for a write byte, SCLK held idle, CS held low.
- `ST_WDATA`: write byte bits.
- `ST_RDATA`: read byte bits.
- `ST_DONE`: CS high, one cycle before ready returns.

The transitions are:

- `ST_IDLE`→`ST_CMD` on acceptance.
- `ST_CMD`→`ST_DONE` for command-only kinds, or `ST_CMD`→`ST_ADDR`.
- `ST_ADDR`→`ST_DONE` when the count is zero, `ST_ADDR`→`ST_WWAIT` for writes, or `ST_ADDR`→`ST_RDATA` for reads.
- `ST_WWAIT`→`ST_WDATA` when a write byte is taken.
- `ST_WDATA`→`ST_WWAIT` while bytes remain, else `ST_WDATA`→`ST_DONE`.
- `ST_RDATA`→`ST_RDATA` while bytes remain, else `ST_RDATA`→`ST_DONE`.
- `ST_DONE`→`ST_IDLE`.

Top module: `spi_cmd_engine`

## Requirements
- R1: An operation is taken only in a cycle where `op_valid` and `op_ready` are both high. `op_ready` is high after reset and while idle. It is low from the cycle after acceptance until one cycle after `cs_n` has returned high. `op_valid` asserted while busy starts nothing.
- R2: `cs_n` is high after reset. It is low from the cycle after acceptance through every phase and every write stall, and it goes high once the last bit has ended.
- R3: `sclk` sits at `CPOL` whenever `cs_n` is high. During a frame each bit shows one system cycle at `CPOL` followed by one cycle at the opposite level. The number of active pulses equals the number of frame bits.
- R4: Data goes out most significant bit first. `mosi` shows bit 31 of `op_word` in the first cycle after acceptance, and `mosi` does not change while `sclk` is at its active level.
- R5: Operation kinds are encoded as 2'b00 = command only, 2'b01 = write, 2'b10 = read, and 2'b11 = command only. The command is `op_word[31:24]` and the address is `op_word[23:0]`. A command-only frame gives 8 pulses; a read or write frame gives 32 + 8×`op_len` pulses.
- R6: A write frame requests each of its `op_len` bytes by raising `wr_ready`. It takes the byte in the cycle `wr_valid` is also high and sends exactly those bytes in order. `wr_ready` never rises in other kinds of frame.
- R7: While `wr_ready` is high and `wr_valid` is low, `sclk` stays at `CPOL`, `cs_n` stays low and the request stays pending.
- R8: A read frame returns `op_len` bytes. Each byte is assembled from MISO sampled at the end of the active half, presented on `rd_data` with `rd_valid` high for exactly one cycle, and `mosi` is low throughout the read data phase.
- R9: A read or write with `op_len` = 0 sends the command and address only, with no write request and no read strobe.
- R10: `op_word`, `op_kind` and `op_len` are captured at acceptance; changing them afterwards does not alter the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Engine idle and able to accept |
| op_kind | input | 2 | Operation kind (R5 encoding) |
| op_word | input | CMD_W+ADDR_W | Command in upper byte, address below |
| op_len | input | LEN_W | Data byte count |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte requested |
| wr_data | input | DATA_W | Write byte |
| rd_valid | output | 1 | One-cycle strobe for a read byte |
| rd_data | output | DATA_W | Read byte |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest condition to reach from the ports is a write stall in the middle of a frame. Here SCLK must freeze at its idle level with chip select still low, and it must resume cleanly once the byte arrives. The stimulus gets there by holding `wr_valid` low for several cycles after `wr_ready` rises, checking the serial pins on every waiting cycle.

A second awkward case is an operation offered while the engine is busy. The bench keeps `op_valid` high with a different operation word throughout a read frame and confirms that only one frame appears on the wire.

Two engines, one per clock polarity, run on the same stimulus, each with its own behavioural slave. The slaves check the frame contents on the wire and return a computed byte pattern.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

    typedef enum logic [1:0] {
        KIND_CMD     = 2'b00,
        KIND_WRITE   = 2'b01,
        KIND_READ    = 2'b10,
        KIND_CMD_ALT = 2'b11
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WWAIT,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } state_e;

endpackage

// File: rtl/spi_sclk_gen.sv
`timescale 1ns/1ps
// Maps the controller's active-half flag onto the serial clock pin.
module spi_sclk_gen #(
    parameter bit CPOL = 1'b0
) (
    input  logic active_half,
    output logic sclk
);
    if (CPOL) begin : g_idle_high
        assign sclk = ~active_half;
    end else begin : g_idle_low
        assign sclk = active_half;
    end
endmodule

// File: rtl/spi_shift_unit.sv
`timescale 1ns/1ps
// Transmit and receive shift registers with the read byte output stage.
module spi_shift_unit #(
    parameter int OP_W   = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_op,
    input  logic              load_wr,
    input  logic              shift_tx,
    input  logic              tx_drive,
    input  logic              miso,
    input  logic              sample_rx,
    input  logic              rx_last,
    output logic              mosi,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int PAD_W = OP_W - DATA_W;

    logic [OP_W-1:0]   tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] rx_next;

    assign rx_next = {rx_q[DATA_W-2:0], miso};
    assign mosi    = tx_drive & tx_q[OP_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load_op) begin
            tx_q <= op_word;
        end else if (load_wr) begin
            tx_q <= {wr_data, {PAD_W{1'b0}}};
        end else if (shift_tx) begin
            tx_q <= {tx_q[OP_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= sample_rx & rx_last;
            if (sample_rx) begin
                rx_q <= rx_next;
                if (rx_last) begin
                    rd_data <= rx_next;
                end
            end
        end
    end
endmodule

// File: rtl/spi_frame_ctrl.sv
`timescale 1ns/1ps
// Frame sequencer: command, address, counted data bytes, end of frame.
module spi_frame_ctrl
    import spi_cmd_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_kind,
    input  logic [LEN_W-1:0] op_len,
    output logic             op_ready,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic             load_op,
    output logic             load_wr,
    output logic             shift_tx,
    output logic             sample_rx,
    output logic             rx_last,
    output logic             tx_drive,
    output logic             cs_n,
    output logic             active_half
);
    localparam int MAX_AC  = (ADDR_W > CMD_W) ? ADDR_W : CMD_W;
    localparam int SEG_MAX = (MAX_AC > DATA_W) ? MAX_AC : DATA_W;
    localparam int CNT_W   = $clog2(SEG_MAX);

    state_e           state_q, state_d;
    op_kind_e         kind_q;
    logic             ph_q;
    logic [CNT_W-1:0] bitcnt_q;
    logic [LEN_W-1:0] left_q;
    logic             shifting;
    logic             bit_end;
    logic             seg_last;
    logic             accept;
    logic             has_addr;
    logic             data_state;

    assign shifting   = (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                        (state_q == ST_WDATA) || (state_q == ST_RDATA);
    assign data_state = (state_q == ST_WDATA) || (state_q == ST_RDATA);
    assign bit_end    = shifting & ph_q;
    assign accept     = op_valid & (state_q == ST_IDLE);
    assign has_addr   = (kind_q == KIND_WRITE) || (kind_q == KIND_READ);

    always_comb begin
        unique case (state_q)
            ST_CMD:             seg_last = (bitcnt_q == CNT_W'(CMD_W - 1));
            ST_ADDR:            seg_last = (bitcnt_q == CNT_W'(ADDR_W - 1));
            ST_WDATA, ST_RDATA: seg_last = (bitcnt_q == CNT_W'(DATA_W - 1));
            default:            seg_last = 1'b0;
        endcase
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_CMD;
            ST_CMD:   if (bit_end && seg_last) state_d = has_addr ? ST_ADDR : ST_DONE;
            ST_ADDR:  if (bit_end && seg_last) begin
                          if (left_q == '0)             state_d = ST_DONE;
                          else if (kind_q == KIND_WRITE) state_d = ST_WWAIT;
                          else                           state_d = ST_RDATA;
                      end
            ST_WWAIT: if (wr_valid) state_d = ST_WDATA;
            ST_WDATA: if (bit_end && seg_last)
                          state_d = (left_q == LEN_W'(1)) ? ST_DONE : ST_WWAIT;
            ST_RDATA: if (bit_end && seg_last)
                          state_d = (left_q == LEN_W'(1)) ? ST_DONE : ST_RDATA;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            kind_q   <= KIND_CMD;
            ph_q     <= 1'b0;
            bitcnt_q <= '0;
            left_q   <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= shifting ? ~ph_q : 1'b0;
            if (accept) begin
                kind_q <= op_kind_e'(op_kind);
                left_q <= op_len;
            end else if (bit_end && seg_last && data_state) begin
                left_q <= left_q - 1'b1;
            end
            if ((bit_end && seg_last) || (state_d != state_q)) begin
                bitcnt_q <= '0;
            end else if (bit_end) begin
                bitcnt_q <= bitcnt_q + 1'b1;
            end
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        op_ready    = (state_q == ST_IDLE);
        cs_n        = (state_q == ST_IDLE) || (state_q == ST_DONE);
        wr_ready    = (state_q == ST_WWAIT);
        load_op     = accept;
        load_wr     = wr_valid & (state_q == ST_WWAIT);
        tx_drive    = (state_q == ST_CMD) || (state_q == ST_ADDR) || (state_q == ST_WDATA);
        shift_tx    = bit_end & tx_drive;
        sample_rx   = bit_end & (state_q == ST_RDATA);
        rx_last     = seg_last;
        active_half = ph_q;
    end
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
// SPI master running command / address / counted-data frames.
module spi_cmd_engine #(
    parameter bit CPOL   = 1'b0,
    parameter int CMD_W  = 8,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_valid,
    output logic                    op_ready,
    input  logic [1:0]              op_kind,
    input  logic [CMD_W+ADDR_W-1:0] op_word,
    input  logic [LEN_W-1:0]        op_len,
    input  logic                    wr_valid,
    output logic                    wr_ready,
    input  logic [DATA_W-1:0]       wr_data,
    output logic                    rd_valid,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    sclk,
    output logic                    cs_n,
    output logic                    mosi,
    input  logic                    miso
);
    localparam int OP_W = CMD_W + ADDR_W;

    logic load_op, load_wr, shift_tx, sample_rx, rx_last, tx_drive, active_half;

    spi_frame_ctrl #(
        .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_kind(op_kind), .op_len(op_len), .op_ready(op_ready),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .load_op(load_op), .load_wr(load_wr), .shift_tx(shift_tx),
        .sample_rx(sample_rx), .rx_last(rx_last), .tx_drive(tx_drive),
        .cs_n(cs_n), .active_half(active_half)
    );

    spi_shift_unit #(.OP_W(OP_W), .DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .op_word(op_word), .wr_data(wr_data),
        .load_op(load_op), .load_wr(load_wr), .shift_tx(shift_tx), .tx_drive(tx_drive),
        .miso(miso), .sample_rx(sample_rx), .rx_last(rx_last),
        .mosi(mosi), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    spi_sclk_gen #(.CPOL(CPOL)) u_sclk (
        .active_half(active_half),
        .sclk(sclk)
    );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
`timescale 1ns/1ps
module spi_cmd_engine_chk #(
    parameter bit CPOL = 1'b0,
    parameter int OP_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic            op_ready,
    input logic [OP_W-1:0] op_word,
    input logic            wr_valid,
    input logic            wr_ready,
    input logic            rd_valid,
    input logic            sclk,
    input logic            cs_n,
    input logic            mosi
);
    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> (!op_ready && !cs_n));

    assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !op_ready);

    assert_ready_after_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> op_ready);

    assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == CPOL));

    assert_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != CPOL) |=> (sclk == CPOL));

    assert_first_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> (mosi == $past(op_word[OP_W-1])));

    assert_mosi_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != CPOL) |-> $stable(mosi));

    assert_stall_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (sclk == CPOL && !cs_n));

    assert_stall_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && !wr_valid) |=> wr_ready);

    assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.CPOL(CPOL), .OP_W(CMD_W + ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_word(op_word), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/spi_slave_model.sv
`timescale 1ns/1ps
// Behavioural mode 0/2 slave: records MOSI on leading edges, shifts a pattern on MISO.
module spi_slave_model #(
    parameter bit CPOL = 1'b0
) (
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    logic [127:0] cap = '0;
    int           nbits = 0;
    logic         so = 1'b0;
    logic         cs_prev = 1'b1;
    logic         sclk_prev = CPOL;

    assign miso = so;

    function automatic logic [7:0] spat(input int n);
        return 8'hC3 ^ 8'(n * 29);
    endfunction

    function automatic logic stream_bit(input int k);
        logic [7:0] b;
        b = spat(k / 8);
        return b[7 - (k % 8)];
    endfunction

    always @(sclk or cs_n) begin
        logic fall_cs, edge_seen, leading;
        fall_cs   = cs_prev && (cs_n == 1'b0);
        edge_seen = (cs_n == 1'b0) && (sclk !== sclk_prev);
        leading   = (sclk != CPOL);
        cs_prev   = cs_n;
        sclk_prev = sclk;
        if (fall_cs) begin
            cap   = '0;
            nbits = 0;
            so    = stream_bit(0);
        end else if (edge_seen) begin
            if (leading) begin
                cap   = {cap[126:0], mosi};
                nbits = nbits + 1;
            end else begin
                #1;
                so = stream_bit(nbits);
            end
        end
    end
endmodule

// File: tb/spi_cmd_engine_test.sv
`timescale 1ns/1ps
module spi_cmd_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [31:0] op_word = '0;
    logic [7:0]  op_len = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;

    logic op_ready_a, wr_ready_a, rd_valid_a, sclk_a, cs_n_a, mosi_a, miso_a;
    logic op_ready_b, wr_ready_b, rd_valid_b, sclk_b, cs_n_b, mosi_b, miso_b;
    logic [7:0] rd_data_a, rd_data_b;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_cmd_engine #(.CPOL(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready_a),
        .op_kind(op_kind), .op_word(op_word), .op_len(op_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready_a), .wr_data(wr_data),
        .rd_valid(rd_valid_a), .rd_data(rd_data_a),
        .sclk(sclk_a), .cs_n(cs_n_a), .mosi(mosi_a), .miso(miso_a)
    );

    spi_cmd_engine #(.CPOL(1'b1)) uut_p1 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready_b),
        .op_kind(op_kind), .op_word(op_word), .op_len(op_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready_b), .wr_data(wr_data),
        .rd_valid(rd_valid_b), .rd_data(rd_data_b),
        .sclk(sclk_b), .cs_n(cs_n_b), .mosi(mosi_b), .miso(miso_b)
    );

    spi_slave_model #(.CPOL(1'b0)) sl_a (.sclk(sclk_a), .cs_n(cs_n_a), .mosi(mosi_a), .miso(miso_a));
    spi_slave_model #(.CPOL(1'b1)) sl_b (.sclk(sclk_b), .cs_n(cs_n_b), .mosi(mosi_b), .miso(miso_b));

    function automatic logic [7:0] spat(input int n);
        return 8'hC3 ^ 8'(n * 29);
    endfunction

    function automatic logic [7:0] wpat(input int n);
        return 8'h5A + 8'(n * 17);
    endfunction

    function automatic logic [7:0] cap_byte(input logic [127:0] cap, input int nbits, input int b);
        int top;
        top = nbits - 1 - 8 * b;
        if (top < 7) return 8'hxx;
        return cap[top -: 8];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic reset_state();
        check(op_ready_a && op_ready_b, "R1", "op_ready after reset", {op_ready_a, op_ready_b}, 2'b11);
        check(cs_n_a && cs_n_b, "R2", "cs_n after reset", {cs_n_a, cs_n_b}, 2'b11);
        check(sclk_a == 1'b0 && sclk_b == 1'b1, "R3", "sclk idle after reset", {sclk_a, sclk_b}, 2'b01);
        check(!rd_valid_a && !rd_valid_b && !wr_ready_a, "R8", "no strobes after reset",
              {rd_valid_a, rd_valid_b, wr_ready_a}, 0);
    endtask

    // Generic frame driver used by every scenario task.
    task automatic run_op(input logic [1:0] kind, input logic [31:0] word, input int len,
                          input int stall, input bit keep_valid);
        int nw, na, nb, wrc, waitc, guard, exp_bits, pa, pb;
        logic [7:0] rb_a[16];
        logic [7:0] rb_b[16];
        bit rw, is_wr, is_rd;
        rw    = (kind == 2'b01) || (kind == 2'b10);
        is_wr = (kind == 2'b01) && (len > 0);
        is_rd = (kind == 2'b10) && (len > 0);
        nw = 0; na = 0; nb = 0; wrc = 0; waitc = 0; guard = 0;
        @(negedge clk);
        op_valid = 1'b1; op_kind = kind; op_word = word; op_len = 8'(len);
        @(negedge clk);
        check(!cs_n_a && !cs_n_b, "R2", "cs_n low after accept", {cs_n_a, cs_n_b}, 0);
        check(!op_ready_a && !op_ready_b, "R1", "ready low after accept", {op_ready_a, op_ready_b}, 0);
        check(mosi_a == word[31] && mosi_b == word[31], "R4", "first bit on mosi",
              {mosi_a, mosi_b}, {word[31], word[31]});
        // R10: scramble the operation inputs once the frame is running
        op_word = ~word; op_kind = ~kind; op_len = 8'hFF;
        op_valid = keep_valid;
        while (!op_ready_a && guard < 20000) begin
            if (rd_valid_a) begin if (na < 16) rb_a[na] = rd_data_a; na++; end
            if (rd_valid_b) begin if (nb < 16) rb_b[nb] = rd_data_b; nb++; end
            if (wr_ready_a) wrc++;
            wr_valid = 1'b0;
            if (wr_ready_a) begin
                if (waitc < stall) begin
                    check(sclk_a == 1'b0 && sclk_b == 1'b1 && !cs_n_a && !cs_n_b && wr_ready_b,
                          "R7", "stalled pins", {sclk_a, sclk_b, cs_n_a, cs_n_b, wr_ready_b}, 5'b01001);
                    waitc++;
                end else begin
                    wr_valid = 1'b1;
                    wr_data  = wpat(nw);
                    nw++;
                    waitc = 0;
                end
            end
            op_valid = keep_valid && !cs_n_a;
            @(negedge clk);
            guard++;
        end
        wr_valid = 1'b0;
        op_valid = 1'b0;
        exp_bits = rw ? 32 + 8 * len : 8;
        check(sl_a.nbits == exp_bits && sl_b.nbits == exp_bits, "R3 R5", "sclk pulse count",
              64'(sl_a.nbits), 64'(exp_bits));
        check(cap_byte(sl_a.cap, sl_a.nbits, 0) == word[31:24] &&
              cap_byte(sl_b.cap, sl_b.nbits, 0) == word[31:24], "R5 R10", "command byte",
              cap_byte(sl_a.cap, sl_a.nbits, 0), word[31:24]);
        if (rw) begin
            check({cap_byte(sl_a.cap, sl_a.nbits, 1), cap_byte(sl_a.cap, sl_a.nbits, 2),
                   cap_byte(sl_a.cap, sl_a.nbits, 3)} == word[23:0] &&
                  {cap_byte(sl_b.cap, sl_b.nbits, 1), cap_byte(sl_b.cap, sl_b.nbits, 2),
                   cap_byte(sl_b.cap, sl_b.nbits, 3)} == word[23:0], "R5 R10", "address bytes",
                  {cap_byte(sl_a.cap, sl_a.nbits, 1), cap_byte(sl_a.cap, sl_a.nbits, 2),
                   cap_byte(sl_a.cap, sl_a.nbits, 3)}, word[23:0]);
        end
        check(nw == (is_wr ? len : 0), "R6 R9", "write bytes taken", 64'(nw), 64'(is_wr ? len : 0));
        if (!is_wr) check(wrc == 0, "R6 R9", "no write request", 64'(wrc), 0);
        for (int i = 0; i < len && is_wr; i++) begin
            check(cap_byte(sl_a.cap, sl_a.nbits, 4 + i) == wpat(i) &&
                  cap_byte(sl_b.cap, sl_b.nbits, 4 + i) == wpat(i), "R6", "write byte on wire",
                  cap_byte(sl_a.cap, sl_a.nbits, 4 + i), wpat(i));
        end
        check(na == (is_rd ? len : 0) && nb == na, "R8 R9", "read strobes", 64'(na), 64'(is_rd ? len : 0));
        for (int i = 0; i < len && is_rd && i < 16; i++) begin
            check(rb_a[i] == spat(4 + i) && rb_b[i] == spat(4 + i), "R8", "read byte",
                  {rb_a[i], rb_b[i]}, {spat(4 + i), spat(4 + i)});
            check(cap_byte(sl_a.cap, sl_a.nbits, 4 + i) == 8'h00, "R8", "mosi low in read data",
                  cap_byte(sl_a.cap, sl_a.nbits, 4 + i), 0);
        end
        check(sclk_a == 1'b0 && sclk_b == 1'b1 && cs_n_a && cs_n_b, "R3", "idle pins after frame",
              {sclk_a, sclk_b, cs_n_a, cs_n_b}, 4'b0111);
        pa = sl_a.nbits; pb = sl_b.nbits;
        repeat (3) @(negedge clk);
        check(cs_n_a && cs_n_b && op_ready_a && sl_a.nbits == pa && sl_b.nbits == pb, "R1",
              "no extra frame", {cs_n_a, cs_n_b, op_ready_a}, 3'b111);
    endtask

    task automatic t_cmd_only();     run_op(2'b00, 32'h9F12_3456, 2, 0, 1'b0); endtask
    task automatic t_cmd_alt();      run_op(2'b11, 32'hAB80_0001, 1, 0, 1'b0); endtask
    task automatic t_write();        run_op(2'b01, 32'h021A_2B3C, 3, 0, 1'b0); endtask
    task automatic t_write_stall();  run_op(2'b01, 32'h0200_FF01, 2, 5, 1'b0); endtask
    task automatic t_read();         run_op(2'b10, 32'h0334_5678, 4, 0, 1'b0); endtask
    task automatic t_read_zero();    run_op(2'b10, 32'h0BAB_CDEF, 0, 0, 1'b0); endtask
    task automatic t_write_zero();   run_op(2'b01, 32'h8601_0203, 0, 0, 1'b0); endtask
    task automatic t_busy_offer();   run_op(2'b10, 32'hE7C0_0A55, 2, 0, 1'b1); endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        reset_state();
        t_cmd_only();
        t_cmd_alt();
        t_write();
        t_write_stall();
        t_read();
        t_read_zero();
        t_write_zero();
        t_busy_offer();
        finish_run();
    end
endmodule